// File: doc/BRIEF.md
# Polled/Interrupt Character Output Port

This block sits on a simple processor bus and hands characters, one at a time, to a slow display device. Software sees two word-wide registers at fixed addresses. The control word at 0xFE04 reports whether the device can take another character and holds an interrupt enable. The character word at 0xFE06 takes the next character to send.

A write to the character word is accepted only while the port is idle. When it is accepted, the low byte goes to the device with a one-cycle valid strobe and the port becomes busy. The device answers with a one-cycle done strobe once it has consumed the byte, after whatever latency it needs, and the port becomes idle again. Software can either poll the idle flag or enable the interrupt line, which stays high for as long as the port is idle and the enable is set.

Top module: `dispout_port`

## Requirements
- R1: After reset the idle flag is 1, the interrupt enable is 0, `irq` is 0 and `dev_valid` is 0.
- R2: A read of address 0xFE04 returns the idle flag in bit 15 and the interrupt enable in bit 14. All other bits are 0. `bus_rdata` is 0 whenever `bus_rd` is low.
- R3: A write to address 0xFE06 while the port is idle makes `dev_valid` high in the next cycle, for exactly one cycle, with `dev_char` equal to bits 7:0 of the written word. The idle flag reads 0 from that cycle on.
- R4: A write to 0xFE06 while the port is busy is dropped. No `dev_valid` follows, `dev_char` keeps its value, and the port stays busy.
- R5: A `dev_done` pulse while the port is busy makes the idle flag 1 in the next cycle. A `dev_done` while the port is already idle has no effect.
- R6: A write to 0xFE04 loads the interrupt enable from bit 14 of the written word. It never changes the idle flag.
- R7: `irq` is 1 exactly when the idle flag and the interrupt enable are both 1.
- R8: A read of 0xFE06 returns 0. Reads of any other address return 0, and writes to any other address change nothing.
- R9: When a write to 0xFE06 meets a `dev_done` in the same cycle while the port is busy, the write is dropped and the port still becomes idle in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | Word address of the access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe; read data is valid in the same cycle |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, 0 when not reading a status word |
| irq | output | 1 | Interrupt request, idle AND enable |
| dev_valid | output | 1 | One-cycle character strobe to the device |
| dev_char | output | 8 | Character byte for the device |
| dev_done | input | 1 | One-cycle strobe: the device has consumed the character |

## Verification
Two functions can fall in the same cycle: the device's done strobe, which frees the port, and a processor write to the character word, which can only be accepted while the port is free. The bench provokes this by driving both strobes on the same clock edge while the port is busy. The write must be judged as dropped: no valid strobe follows and the previous byte is still on `dev_char`. The done strobe must still win, so the control word reads idle in the next cycle. The bench also merges a done strobe with a write to the control word, to show that the enable update and the release of the port both take effect.

// File: rtl/dispout_pkg.sv
package dispout_pkg;
  localparam int unsigned WORD_W    = 16;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned IDLE_POS  = 15;
  localparam int unsigned IEN_POS   = 14;
  localparam logic [WORD_W-1:0] CTRL_ADDR = 16'hFE04;
  localparam logic [WORD_W-1:0] CHAR_ADDR = 16'hFE06;

  // Build the visible control word from the two state bits.
  function automatic logic [WORD_W-1:0] pack_ctrl(input logic idle, input logic ien);
    logic [WORD_W-1:0] w;
    w = '0;
    w[IDLE_POS] = idle;
    w[IEN_POS]  = ien;
    return w;
  endfunction
endpackage

// File: rtl/dispout_decode.sv
module dispout_decode #(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] CTRL_AT = 16'hFE04,
  parameter logic [ADDR_W-1:0] CHAR_AT = 16'hFE06
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  output logic              ctrl_wr_hit,
  output logic              char_wr_hit,
  output logic              ctrl_rd_hit
);
  logic ctrl_sel;
  logic char_sel;

  assign ctrl_sel    = (addr == CTRL_AT);
  assign char_sel    = (addr == CHAR_AT);
  assign ctrl_wr_hit = wr & ctrl_sel;
  assign char_wr_hit = wr & char_sel;
  assign ctrl_rd_hit = rd & ctrl_sel;
endmodule

// File: rtl/dispout_state.sv
module dispout_state (
  input  logic clk,
  input  logic rst_n,
  input  logic ctrl_wr_hit,
  input  logic ien_in,
  input  logic take_char,
  input  logic done_in,
  output logic idle_q,
  output logic ien_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idle_q <= 1'b1;
      ien_q  <= 1'b0;
    end else begin
      if (take_char) begin
        idle_q <= 1'b0;
      end else if (done_in && !idle_q) begin
        idle_q <= 1'b1;
      end
      if (ctrl_wr_hit) begin
        ien_q <= ien_in;
      end
    end
  end
endmodule

// File: rtl/dispout_txreg.sv
module dispout_txreg #(
  parameter int unsigned CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_char,
  input  logic [CHAR_W-1:0] char_in,
  output logic              valid_q,
  output logic [CHAR_W-1:0] char_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      char_q  <= '0;
    end else begin
      valid_q <= take_char;
      if (take_char) begin
        char_q <= char_in;
      end
    end
  end
endmodule

// File: rtl/dispout_port.sv
module dispout_port
  import dispout_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              irq,
  output logic              dev_valid,
  output logic [BYTE_W-1:0] dev_char,
  input  logic              dev_done
);
  logic ctrl_wr_hit;
  logic char_wr_hit;
  logic ctrl_rd_hit;
  logic idle_q;
  logic ien_q;
  logic take_char;

  dispout_decode #(
    .ADDR_W (WORD_W),
    .CTRL_AT(CTRL_ADDR),
    .CHAR_AT(CHAR_ADDR)
  ) i_decode (
    .addr       (bus_addr),
    .wr         (bus_wr),
    .rd         (bus_rd),
    .ctrl_wr_hit(ctrl_wr_hit),
    .char_wr_hit(char_wr_hit),
    .ctrl_rd_hit(ctrl_rd_hit)
  );

  // A character is taken only while the port is idle.
  assign take_char = char_wr_hit & idle_q;

  dispout_state i_state (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_wr_hit(ctrl_wr_hit),
    .ien_in     (bus_wdata[IEN_POS]),
    .take_char  (take_char),
    .done_in    (dev_done),
    .idle_q     (idle_q),
    .ien_q      (ien_q)
  );

  dispout_txreg #(.CHAR_W(BYTE_W)) i_txreg (
    .clk      (clk),
    .rst_n    (rst_n),
    .take_char(take_char),
    .char_in  (bus_wdata[BYTE_W-1:0]),
    .valid_q  (dev_valid),
    .char_q   (dev_char)
  );

  assign bus_rdata = ctrl_rd_hit ? pack_ctrl(idle_q, ien_q) : '0;
  assign irq       = idle_q & ien_q;
endmodule

// File: rtl/dispout_checks.sv
module dispout_checks (
  input logic clk,
  input logic rst_n,
  input logic dev_valid,
  input logic dev_done,
  input logic irq,
  input logic idle_q,
  input logic ien_q,
  input logic take_char,
  input logic char_wr_hit,
  input logic ctrl_wr_hit
);
  // R3: a strobe lasts one cycle
  p_valid_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dev_valid |=> !dev_valid);
  // R3: a taken character makes the port busy and strobes the device
  p_take_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    take_char |=> (!idle_q && dev_valid));
  // R4: a write while busy produces no strobe
  p_drop_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (char_wr_hit && !idle_q) |=> !dev_valid);
  // R5, R9: done while busy frees the port
  p_done_frees_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_done && !idle_q) |=> idle_q);
  // R6: a control write leaves the idle flag alone
  p_ctrl_keeps_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr_hit && !dev_done && !take_char) |=> $stable(idle_q));
  // R7: irq only rises when enable or done caused it
  p_irq_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (ien_q && ($past(dev_done) || $past(ctrl_wr_hit))));
endmodule

bind dispout_port dispout_checks i_checks (
  .clk        (clk),
  .rst_n      (rst_n),
  .dev_valid  (dev_valid),
  .dev_done   (dev_done),
  .irq        (irq),
  .idle_q     (idle_q),
  .ien_q      (ien_q),
  .take_char  (take_char),
  .char_wr_hit(char_wr_hit),
  .ctrl_wr_hit(ctrl_wr_hit)
);

// File: tb/test_dispout_port.sv
module test_dispout_port;
  localparam int DEV_LAT = 5;
  localparam logic [15:0] A_CTRL = 16'hFE04;
  localparam logic [15:0] A_CHAR = 16'hFE06;
  // bit 8 = enable to program, bits 7:0 = character
  localparam logic [8:0] VEC [0:7] = '{9'h141, 9'h042, 9'h17E, 9'h000,
                                       9'h1FF, 9'h00A, 9'h120, 9'h05A};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq;
  logic        dev_valid;
  logic [7:0]  dev_char;
  logic        dev_done = 1'b0;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  dispout_port i_dispout_port (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .dev_valid(dev_valid), .dev_char(dev_char), .dev_done(dev_done)
  );

  function automatic logic [15:0] ctrl_word(input logic idle, input logic ien);
    return {idle, ien, 14'd0};
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d, input logic done_too);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1; dev_done = done_too;
    @(negedge clk);
    bus_wr = 1'b0; dev_done = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic done_pulse();
    @(negedge clk);
    dev_done = 1'b1;
    @(negedge clk);
    dev_done = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] r;
    logic [7:0] held;
    logic ien;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 irq", {15'd0, irq}, 16'd0);
    chk("R1 dev_valid", {15'd0, dev_valid}, 16'd0);
    rd(A_CTRL, r);
    chk("R1 ctrl after reset", r, ctrl_word(1'b1, 1'b0));
    // R2: no read strobe gives zero
    #1 chk("R2 rdata idle bus", bus_rdata, 16'd0);

    // Vector loop: R2 R3 R5 R7
    for (int i = 0; i < 8; i++) begin
      ien = VEC[i][8];
      wr(A_CTRL, {1'b0, ien, 14'h3FFF}, 1'b0);
      chk("R7 irq when idle", {15'd0, irq}, {15'd0, ien});
      wr(A_CHAR, {8'hC3, VEC[i][7:0]}, 1'b0);
      chk("R3 valid strobe", {15'd0, dev_valid}, 16'd1);
      chk("R3 char byte", {8'd0, dev_char}, {8'd0, VEC[i][7:0]});
      rd(A_CTRL, r);
      chk("R3 strobe one cycle", {15'd0, dev_valid}, 16'd0);
      chk("R2 ctrl busy", r, ctrl_word(1'b0, ien));
      chk("R7 irq busy", {15'd0, irq}, 16'd0);
      repeat (DEV_LAT) @(negedge clk);
      done_pulse();
      rd(A_CTRL, r);
      chk("R5 idle after done", r, ctrl_word(1'b1, ien));
      chk("R7 irq after done", {15'd0, irq}, {15'd0, ien});
    end

    // R5: stray done while idle
    wr(A_CTRL, 16'h0000, 1'b0);
    done_pulse();
    chk("R5 stray done no strobe", {15'd0, dev_valid}, 16'd0);
    rd(A_CTRL, r);
    chk("R5 stray done idle", r, ctrl_word(1'b1, 1'b0));

    // R8: other addresses
    rd(A_CHAR, r);
    chk("R8 char word reads zero", r, 16'd0);
    rd(16'hFE00, r);
    chk("R8 other read zero", r, 16'd0);
    held = dev_char;
    wr(16'hFE05, 16'h4077, 1'b0);
    chk("R8 stray write no strobe", {15'd0, dev_valid}, 16'd0);
    rd(A_CTRL, r);
    chk("R8 stray write no change", r, ctrl_word(1'b1, 1'b0));

    // R4: write while busy
    wr(A_CHAR, 16'h0031, 1'b0);
    held = dev_char;
    chk("R3 corner char", {8'd0, held}, 16'h0031);
    @(negedge clk);
    wr(A_CHAR, 16'h0032, 1'b0);
    chk("R4 no strobe when busy", {15'd0, dev_valid}, 16'd0);
    chk("R4 char kept", {8'd0, dev_char}, {8'd0, held});
    rd(A_CTRL, r);
    chk("R4 still busy", r, ctrl_word(1'b0, 1'b0));

    // R6: ctrl write while busy keeps busy
    wr(A_CTRL, 16'hFFFF, 1'b0);
    rd(A_CTRL, r);
    chk("R6 enable set, still busy", r, ctrl_word(1'b0, 1'b1));
    chk("R7 no irq busy", {15'd0, irq}, 16'd0);

    // R9: write and done in the same cycle while busy
    wr(A_CHAR, 16'h0039, 1'b1);
    chk("R9 write dropped", {15'd0, dev_valid}, 16'd0);
    chk("R9 char kept", {8'd0, dev_char}, {8'd0, held});
    rd(A_CTRL, r);
    chk("R9 idle after merge", r, ctrl_word(1'b1, 1'b1));
    chk("R7 irq after merge", {15'd0, irq}, 16'd1);

    // R6: ctrl write with done, both take effect
    wr(A_CHAR, 16'h0044, 1'b0);
    wr(A_CTRL, 16'h0000, 1'b1);
    rd(A_CTRL, r);
    chk("R6 enable clear with done", r, ctrl_word(1'b1, 1'b0));

    // R1: reset mid-transfer
    wr(A_CHAR, 16'h0055, 1'b0);
    wr(A_CTRL, 16'h4000, 1'b0);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd(A_CTRL, r);
    chk("R1 ctrl after second reset", r, ctrl_word(1'b1, 1'b0));
    chk("R1 irq after second reset", {15'd0, irq}, 16'd0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule